// File: doc/BRIEF.md
# Shadowed Multi-Byte Control Registers

This block is a bank of byte-wide control registers. A host reaches it over a plain parallel bus: an address, a write byte, a write strobe and a read byte. The bank holds a clock-divider word, a sampling-phase code, and a gain and an offset for each of three colour channels. The serial protocol engine that usually sits in front of the bank is a separate block. Any setting wider than one byte is spread over two neighbouring addresses. The first address holds the upper byte. The second holds the few remaining low bits.

The upper byte of a wide setting first goes into a staging register. The downstream logic sees no change until the host writes the low part. That single write then loads the staged byte and the new low bits into the live output together, so the logic that uses the setting never sees half of an update. Each live setting has its own one-cycle commit pulse, and this pulse tells the consumer that a new value has arrived. The bank also returns a fixed revision byte and a status byte, and it loads documented defaults at reset.

Top module: `ctlreg_bank`

## Requirements
- R1: After a synchronous active-low reset the outputs hold these values: divider 1693 (0x69D), each gain 256 (0x100), each offset 512 (0x200), phase 16. All commit pulses are low.
- R2: A write to an upper-byte address changes only the staging register. The live value stays as it was and no commit pulse is raised.
- R3: A write to a low-part address loads {staged upper byte, new low bits} into the live value at that clock edge. The matching commit pulse is high for exactly the following cycle.
- R4: The 12-bit divider takes bits [11:4] from byte 0x01 and bits [3:0] from bits [7:4] of byte 0x02.
- R5: Each 9-bit gain takes bits [8:2] from bits [6:0] of its upper byte and bits [1:0] from bits [7:6] of its low byte. The address pairs are 0x05/0x06 for red (index 0), 0x07/0x08 for green (index 1) and 0x09/0x0A for blue (index 2).
- R6: Each 11-bit offset takes bits [10:3] from its upper byte and bits [2:0] from bits [7:5] of its low byte. The address pairs are 0x0B/0x0C for red, 0x0D/0x0E for green and 0x0F/0x10 for blue.
- R7: The 5-bit phase sits in bits [7:3] of byte 0x04. A write to 0x04 takes effect at once and raises no commit pulse.
- R8: Reading an upper-byte address returns the staged byte. Reading a low-part address returns the live low bits in their field position. Every bit that is not implemented reads as 0.
- R9: Byte 0x00 reads as the REVISION parameter and byte 0x11 reads as the status_in input. Writes to either of them, and writes to any address that is not defined, change no output. Undefined addresses read as 0.
- R10: Only the parameter whose low part was written raises its commit pulse. At most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_we | input | 1 | Write strobe, one write per cycle |
| host_rdata | output | 8 | Read byte for host_addr, combinational |
| status_in | input | 8 | Status byte returned at 0x11 |
| pll_div | output | 12 | Live divider word |
| pll_commit | output | 1 | Divider update pulse |
| phase_adj | output | 5 | Sampling phase code |
| gain_live | output | 27 | Three 9-bit gains, red in the lowest bits |
| gain_commit | output | 3 | Gain update pulses, one per channel |
| offset_live | output | 33 | Three 11-bit offsets, red in the lowest bits |
| offset_commit | output | 3 | Offset update pulses, one per channel |

## Verification
The bench first writes an upper byte alone and then reads back both the live output and the staged byte. A bank that forwarded the byte straight to the output would show the new divider too early. A low-part write with no new upper byte must commit the value that was staged earlier, and a bank that cleared or lost the staging register would commit the wrong upper bits. The bench writes all-ones bytes to the partial fields so that a wrong mask or a shifted field position shows up in both the live value and the read-back byte. It also writes to the revision address and to an undefined address, and it checks the commit-pulse vector after each write, which catches a pulse on the wrong channel or a pulse that lasts more than one cycle.

// File: rtl/ctlreg_pkg.sv
// Package: shared widths, register addresses and reset values for the
// control register bank. Assumes byte-wide host data.
package ctlreg_pkg;
    localparam int BYTE_W   = 8;
    localparam int NCH      = 3;
    localparam int PLL_W    = 12;
    localparam int PLL_LSBW = 4;
    localparam int GAIN_W   = 9;
    localparam int GAIN_LSBW = 2;
    localparam int OFFS_W   = 11;
    localparam int OFFS_LSBW = 3;
    localparam int PHASE_W  = 5;
    localparam int NWREG    = 17;   // writable byte slots 0x00..0x10

    localparam logic [7:0] A_REV       = 8'h00;
    localparam logic [7:0] A_PLL_MSB   = 8'h01;
    localparam logic [7:0] A_PLL_LSB   = 8'h02;
    localparam logic [7:0] A_PHASE     = 8'h04;
    localparam logic [7:0] A_GAIN_BASE = 8'h05;
    localparam logic [7:0] A_OFFS_BASE = 8'h0B;
    localparam logic [7:0] A_STATUS    = 8'h11;

    localparam logic [7:0] PLL_MSB_RST  = 8'h69;
    localparam logic [3:0] PLL_LSB_RST  = 4'hD;
    localparam logic [6:0] GAIN_MSB_RST = 7'b100_0000;
    localparam logic [1:0] GAIN_LSB_RST = 2'b00;
    localparam logic [7:0] OFFS_MSB_RST = 8'h40;
    localparam logic [2:0] OFFS_LSB_RST = 3'b000;
    localparam logic [4:0] PHASE_RST    = 5'd16;
endpackage

// File: rtl/ctlreg_decode.sv
// Module: address decoder. Turns one host write into a one-hot write
// enable per writable byte slot. Slot 0 (revision) never gets an enable.
// Assumes at most one write per cycle.
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter int SLOTS = NWREG
) (
    input  logic             we,
    input  logic [7:0]       addr,
    output logic [SLOTS-1:0] slot_we
);
    assign slot_we[0] = 1'b0;
    for (genvar i = 1; i < SLOTS; i++) begin : g_slot
        // enable slot i when the write targets its address
        assign slot_we[i] = we && (addr == 8'(i));
    end
endmodule

// File: rtl/ctlreg_split.sv
// Module: one double-buffered wide setting. The upper byte goes to a
// staging register. A write of the low part loads staged byte + new low
// bits into the live value and raises commit for one cycle.
// Assumes msb_we and lsb_we are never high together.
module ctlreg_split #(
    parameter int              MSB_W   = 8,
    parameter int              LSB_W   = 4,
    parameter int              LSB_POS = 4,
    parameter logic [MSB_W-1:0] MSB_RST = '0,
    parameter logic [LSB_W-1:0] LSB_RST = '0,
    localparam int             FULL_W  = MSB_W + LSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msb_we,
    input  logic              lsb_we,
    input  logic [7:0]        wdata,
    output logic [7:0]        stage_rd,
    output logic [7:0]        lsb_rd,
    output logic [FULL_W-1:0] live,
    output logic              commit
);
    logic [MSB_W-1:0] stage_q;

    // staging register: captures the upper byte only
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= MSB_RST;
        else if (msb_we) stage_q <= wdata[MSB_W-1:0];
    end

    // live register and commit pulse: updated only by the low-part write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= {MSB_RST, LSB_RST};
            commit <= 1'b0;
        end else begin
            commit <= lsb_we;
            if (lsb_we) live <= {stage_q, wdata[LSB_POS +: LSB_W]};
        end
    end

    // read-back: staged byte and live low bits, unused bits zero
    assign stage_rd = 8'(stage_q);
    assign lsb_rd   = 8'(live[LSB_W-1:0]) << LSB_POS;
endmodule

// File: rtl/ctlreg_bank.sv
// Module: top of the control register bank. Decodes host writes, holds
// the divider, phase, gains and offsets, and builds the read byte.
// Assumes a single-cycle write strobe and a combinational read.
module ctlreg_bank
    import ctlreg_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'hA3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              host_addr,
    input  logic [7:0]              host_wdata,
    input  logic                    host_we,
    output logic [7:0]              host_rdata,
    input  logic [7:0]              status_in,
    output logic [PLL_W-1:0]        pll_div,
    output logic                    pll_commit,
    output logic [PHASE_W-1:0]      phase_adj,
    output logic [NCH*GAIN_W-1:0]   gain_live,
    output logic [NCH-1:0]          gain_commit,
    output logic [NCH*OFFS_W-1:0]   offset_live,
    output logic [NCH-1:0]          offset_commit
);
    logic [NWREG-1:0] slot_we;
    logic [7:0] pll_stage_rd, pll_lsb_rd;
    logic [7:0] gain_stage_rd [NCH];
    logic [7:0] gain_lsb_rd   [NCH];
    logic [7:0] offs_stage_rd [NCH];
    logic [7:0] offs_lsb_rd   [NCH];

    ctlreg_decode #(.SLOTS(NWREG)) u_dec (
        .we(host_we), .addr(host_addr), .slot_we(slot_we)
    );

    ctlreg_split #(
        .MSB_W(PLL_W - PLL_LSBW), .LSB_W(PLL_LSBW), .LSB_POS(4),
        .MSB_RST(PLL_MSB_RST), .LSB_RST(PLL_LSB_RST)
    ) u_pll (
        .clk(clk), .rst_n(rst_n),
        .msb_we(slot_we[A_PLL_MSB]), .lsb_we(slot_we[A_PLL_LSB]),
        .wdata(host_wdata), .stage_rd(pll_stage_rd), .lsb_rd(pll_lsb_rd),
        .live(pll_div), .commit(pll_commit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int GA = int'(A_GAIN_BASE) + 2*c;
        localparam int OA = int'(A_OFFS_BASE) + 2*c;

        ctlreg_split #(
            .MSB_W(GAIN_W - GAIN_LSBW), .LSB_W(GAIN_LSBW), .LSB_POS(6),
            .MSB_RST(GAIN_MSB_RST), .LSB_RST(GAIN_LSB_RST)
        ) u_gain (
            .clk(clk), .rst_n(rst_n),
            .msb_we(slot_we[GA]), .lsb_we(slot_we[GA+1]),
            .wdata(host_wdata), .stage_rd(gain_stage_rd[c]),
            .lsb_rd(gain_lsb_rd[c]),
            .live(gain_live[c*GAIN_W +: GAIN_W]), .commit(gain_commit[c])
        );

        ctlreg_split #(
            .MSB_W(OFFS_W - OFFS_LSBW), .LSB_W(OFFS_LSBW), .LSB_POS(5),
            .MSB_RST(OFFS_MSB_RST), .LSB_RST(OFFS_LSB_RST)
        ) u_offs (
            .clk(clk), .rst_n(rst_n),
            .msb_we(slot_we[OA]), .lsb_we(slot_we[OA+1]),
            .wdata(host_wdata), .stage_rd(offs_stage_rd[c]),
            .lsb_rd(offs_lsb_rd[c]),
            .live(offset_live[c*OFFS_W +: OFFS_W]), .commit(offset_commit[c])
        );
    end

    // phase register: single byte, takes effect on write
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase_adj <= PHASE_RST;
        else if (slot_we[A_PHASE])   phase_adj <= host_wdata[7:3];
    end

    // read multiplexer: fixed bytes first, then per-channel pairs
    always_comb begin
        host_rdata = 8'h00;
        unique case (host_addr)
            A_REV:     host_rdata = REVISION;
            A_PLL_MSB: host_rdata = pll_stage_rd;
            A_PLL_LSB: host_rdata = pll_lsb_rd;
            A_PHASE:   host_rdata = {phase_adj, 3'b000};
            A_STATUS:  host_rdata = status_in;
            default:   host_rdata = 8'h00;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (host_addr == A_GAIN_BASE + 8'(2*c))     host_rdata = gain_stage_rd[c];
            if (host_addr == A_GAIN_BASE + 8'(2*c + 1)) host_rdata = gain_lsb_rd[c];
            if (host_addr == A_OFFS_BASE + 8'(2*c))     host_rdata = offs_stage_rd[c];
            if (host_addr == A_OFFS_BASE + 8'(2*c + 1)) host_rdata = offs_lsb_rd[c];
        end
    end
endmodule

// File: rtl/ctlreg_bank_chk.sv
// Module: property checker for ctlreg_bank, attached by bind below.
// Observes the ports only.
module ctlreg_bank_chk
    import ctlreg_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'hA3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            host_addr,
    input logic [7:0]            host_wdata,
    input logic                  host_we,
    input logic [7:0]            host_rdata,
    input logic [PLL_W-1:0]      pll_div,
    input logic                  pll_commit,
    input logic [PHASE_W-1:0]    phase_adj,
    input logic [NCH*GAIN_W-1:0] gain_live,
    input logic [NCH-1:0]        gain_commit,
    input logic [NCH*OFFS_W-1:0] offset_live,
    input logic [NCH-1:0]        offset_commit
);
    logic pll_msb_wr, pll_lsb_wr, undef_wr;
    assign pll_msb_wr = host_we && host_addr == A_PLL_MSB;
    assign pll_lsb_wr = host_we && host_addr == A_PLL_LSB;
    assign undef_wr   = host_we && host_addr > A_STATUS;

    a_r2_msb_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pll_msb_wr |=> $stable(pll_div) && !pll_commit);

    a_r3_lsb_write_commits: assert property (@(posedge clk) disable iff (!rst_n)
        pll_lsb_wr |=> pll_commit && pll_div[3:0] == $past(host_wdata[7:4]));

    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pll_commit && !pll_lsb_wr |=> !pll_commit);

    a_r10_commit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pll_commit, gain_commit, offset_commit}));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r3_gain_moves_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !gain_commit[c] |-> $stable(gain_live[c*GAIN_W +: GAIN_W]));
        a_r3_offs_moves_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !offset_commit[c] |-> $stable(offset_live[c*OFFS_W +: OFFS_W]));
    end

    a_r9_revision_read: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == A_REV |-> host_rdata == REVISION);

    a_r9_undef_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        undef_wr |=> $stable(pll_div) && $stable(phase_adj)
                     && $stable(gain_live) && $stable(offset_live));
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.REVISION(REVISION)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .pll_div(pll_div),
    .pll_commit(pll_commit), .phase_adj(phase_adj), .gain_live(gain_live),
    .gain_commit(gain_commit), .offset_live(offset_live),
    .offset_commit(offset_commit)
);

// File: tb/ctlreg_bank_bench.sv
// Scoreboard bench: the driver pushes expected items into a queue and
// the monitor task pops each item and compares it with the ports.
module ctlreg_bank_bench;
    localparam logic [7:0] REV = 8'hA3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0, host_rdata, status_in = 8'h5A;
    logic        host_we = 1'b0;
    logic [11:0] pll_div;
    logic        pll_commit;
    logic [4:0]  phase_adj;
    logic [26:0] gain_live;
    logic [2:0]  gain_commit;
    logic [32:0] offset_live;
    logic [2:0]  offset_commit;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int          sel;   // 0 read, 1 pll, 2-4 gain, 5-7 offset, 8 phase, 9 commits
        logic [7:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    ctlreg_bank #(.REVISION(REV)) u_ctlreg_bank (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .status_in(status_in),
        .pll_div(pll_div), .pll_commit(pll_commit), .phase_adj(phase_adj),
        .gain_live(gain_live), .gain_commit(gain_commit),
        .offset_live(offset_live), .offset_commit(offset_commit)
    );

    task automatic push(input int sel, input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        it.sel = sel; it.addr = a; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // monitor: pops every queued item and compares with the ports
    task automatic drain();
        logic [31:0] act;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            act = '0;
            case (it.sel)
                0: begin
                    @(negedge clk); host_addr = it.addr; #1;
                    act = 32'(host_rdata);
                end
                1: act = 32'(pll_div);
                2, 3, 4: act = 32'(gain_live[(it.sel-2)*9 +: 9]);
                5, 6, 7: act = 32'(offset_live[(it.sel-5)*11 +: 11]);
                8: act = 32'(phase_adj);
                default: act = 32'({pll_commit, gain_commit, offset_commit});
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d addr=%02h actual=%0h expected=%0h",
                         it.req, it.sel, it.addr, act, it.exp);
            end
        end
    endtask

    task automatic push_defaults(input string r);
        push(9, 0, 0, r);
        push(1, 0, 32'h69D, r);
        for (int c = 0; c < 3; c++) push(2+c, 0, 32'h100, r);
        for (int c = 0; c < 3; c++) push(5+c, 0, 32'h200, r);
        push(8, 0, 16, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and R8 default read-back
        push_defaults("R1");
        push(0, 8'h00, REV, "R9");
        push(0, 8'h01, 8'h69, "R8");
        push(0, 8'h02, 8'hD0, "R8");
        push(0, 8'h05, 8'h40, "R8");
        push(0, 8'h06, 8'h00, "R8");
        push(0, 8'h0B, 8'h40, "R8");
        push(0, 8'h04, 8'h80, "R7");
        drain();

        // R2 upper byte alone: live unchanged, staged byte readable
        wr(8'h01, 8'h12);
        push(9, 0, 0, "R2");
        push(1, 0, 32'h69D, "R2");
        push(0, 8'h01, 8'h12, "R8");
        push(0, 8'h02, 8'hD0, "R8");
        drain();

        // R3/R4 low part commits, pulse lasts one cycle
        wr(8'h02, 8'h7F);
        push(9, 0, 32'b1000000, "R3");
        push(1, 0, 32'h127, "R4");
        push(0, 8'h02, 8'h70, "R8");
        push(9, 0, 0, "R3");
        drain();

        // R3 low part again without a new upper byte: staged byte reused
        wr(8'h02, 8'hA0);
        push(1, 0, 32'h12A, "R3");
        push(0, 8'h02, 8'hA0, "R4");
        drain();

        // R5 green gain, all-ones fields
        wr(8'h07, 8'hFF);
        push(2+1, 0, 32'h100, "R5");
        push(0, 8'h07, 8'h7F, "R8");
        drain();
        wr(8'h08, 8'hC5);
        push(9, 0, 32'b0010000, "R10");
        push(2+1, 0, 32'h1FF, "R5");
        push(2+0, 0, 32'h100, "R10");
        push(2+2, 0, 32'h100, "R10");
        push(0, 8'h08, 8'hC0, "R8");
        drain();

        // R6 blue and red offsets
        wr(8'h0F, 8'hAB);
        wr(8'h10, 8'hFF);
        push(9, 0, 32'b0000100, "R10");
        push(5+2, 0, 32'h55F, "R6");
        push(0, 8'h10, 8'hE0, "R8");
        push(0, 8'h0F, 8'hAB, "R8");
        drain();
        wr(8'h0B, 8'h01);
        wr(8'h0C, 8'h20);
        push(9, 0, 32'b0000001, "R10");
        push(5+0, 0, 32'h009, "R6");
        push(5+1, 0, 32'h200, "R6");
        push(0, 8'h0C, 8'h20, "R6");
        drain();

        // R7 phase, low bits ignored, no pulse
        wr(8'h04, 8'hFF);
        push(9, 0, 0, "R7");
        push(8, 0, 31, "R7");
        push(0, 8'h04, 8'hF8, "R7");
        drain();
        wr(8'h04, 8'h07);
        push(8, 0, 0, "R7");
        drain();

        // R9 revision, status and undefined addresses
        wr(8'h00, 8'h55);
        wr(8'h11, 8'h00);
        wr(8'h3F, 8'hFF);
        push(9, 0, 0, "R9");
        push(1, 0, 32'h12A, "R9");
        push(2+1, 0, 32'h1FF, "R9");
        push(5+2, 0, 32'h55F, "R9");
        push(8, 0, 0, "R9");
        push(0, 8'h00, REV, "R9");
        push(0, 8'h11, 8'h5A, "R9");
        push(0, 8'h3F, 8'h00, "R9");
        push(0, 8'h03, 8'h00, "R9");
        drain();

        // R1 reset in mid-run restores defaults and staging
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_defaults("R1");
        push(0, 8'h01, 8'h69, "R1");
        push(0, 8'h07, 8'h40, "R1");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule